// File: doc/BRIEF.md
# ADC Control and Status Register

This block is the register that a processor uses to drive a successive-approximation analog-to-digital converter. It holds a 5-bit channel number, a continuous-conversion enable and an interrupt enable. Each write to it launches a conversion on the channel just written. The converter returns a one-cycle done strobe when a conversion finishes. The block turns that strobe into a completion flag or an interrupt request. In continuous mode it starts the next conversion by itself.

The top bit has two meanings, chosen by the interrupt enable. With interrupts off, it is a read-only completion flag. In a continuous run this flag is raised only by the first conversion. With interrupts on, the processor can write the bit, and it selects where a finished conversion is reported. A 0 sends it to the processor interrupt line. A 1 sends it to a transfer path that does not exist here, so a 1 silences the interrupt.

The bus has one register-select bit. Select 0 addresses this register. Select 1 addresses the converter's data register, and a read at select 1 is the data-register read that acknowledges a result.

Top module: `adc_ctl_reg`

## Requirements
- R1: After reset, the register reads 0x1F: bit 7 = 0, bit 6 (interrupt enable) = 0, bit 5 (continuous) = 0, bits 4..0 (channel) = 31. The channel output is 31, and the start, continuous and interrupt outputs are 0.
- R2: A write with select 0 loads bits 6..0 from the bus on the next clock edge. If the written bit 6 is 0, bit 7 reads 0 afterwards, whatever value was written to it.
- R3: With bit 6 = 0 and bit 5 = 0, each done strobe sets bit 7 on the next edge.
- R4: With bit 6 = 0 and bit 5 = 1, only the first done strobe after the register is written sets bit 7. Once bit 7 has been cleared, later done strobes in the same run leave it at 0.
- R5: With bit 6 = 0, a read with select 1 clears bit 7 on the next edge. A write with select 0 also clears it (see R2). If a done strobe comes in the same cycle as such a read, the done strobe wins.
- R6: With bit 6 = 1, bit 7 holds the value last written to it, and a read with select 1 does not change it.
- R7: With bit 6 = 1 and bit 7 = 0, a done strobe raises the interrupt output on the next edge. The output stays high until a read with select 1 or a write with select 0.
- R8: With bit 6 = 1 and bit 7 = 1, done strobes never raise the interrupt output.
- R9: A write with select 0 gives a start pulse that lasts one cycle, in the cycle after the write, if the written channel is not 31. If the written channel is 31, no start pulse is issued. The channel output always shows bits 4..0.
- R10: With bit 5 = 1 and the channel not 31, each done strobe gives a start pulse in the next cycle. This continues until a write clears bit 5 or sets the channel to 31.
- R11: If a write with select 0 and a done strobe come in the same cycle, the write wins. With the written bit 6 = 0, bit 7 ends at 0, and no interrupt is raised.
- R12: A write with select 1 changes nothing. A read with select 0 has no side effect. The read-data bus carries the register only during a read with select 0 and is 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_sel | input | 1 | Register select: 0 = control/status, 1 = data register |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the control/status register |
| conv_done | input | 1 | One-cycle strobe from the converter at the end of a conversion |
| start_conv | output | 1 | One-cycle request to start a conversion |
| chan | output | 5 | Selected channel |
| cont_mode | output | 1 | Continuous-conversion level |
| cpu_irq | output | 1 | Processor interrupt request |

## Verification
Four patterns exercise the completion path. The first is a single conversion with interrupts off, which shows that the flag sets on each done strobe. The second is a continuous run with interrupts off, which separates a flag that sets only once per run from one that sets on every done. The third is interrupts on with processor routing, which shows that the request is held until an acknowledge. The fourth is interrupts on with transfer routing, which shows that the request is masked and that the written bit survives a data read. Collision cycles, where a write meets a done strobe, show which event has priority. Writes to channel 31 and writes with select 1 show that idle and ignored accesses cause no start and change no state.

// File: rtl/adc_ctl_reg.sv
module adc_ctl_reg #(
  parameter int DW  = 8,
  parameter int CHW = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_sel,
  input  logic           wr_en,
  input  logic           rd_en,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rdata,
  input  logic           conv_done,
  output logic           start_conv,
  output logic [CHW-1:0] chan,
  output logic           cont_mode,
  output logic           cpu_irq
);
  localparam int CONT_B = CHW;
  localparam int IEN_B  = CHW + 1;
  localparam int FLAG_B = CHW + 2;
  localparam logic [CHW-1:0] CH_IDLE = '1;

  logic flag, ien, cont, first, irq_q, start_q;
  logic [CHW-1:0] ch;

  wire ctl_wr  = wr_en & ~reg_sel;
  wire data_rd = rd_en &  reg_sel;
  wire ctl_rd  = rd_en & ~reg_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag    <= 1'b0;
      ien     <= 1'b0;
      cont    <= 1'b0;
      ch      <= CH_IDLE;
      first   <= 1'b0;
      irq_q   <= 1'b0;
      start_q <= 1'b0;
    end else if (ctl_wr) begin
      ien     <= wdata[IEN_B];
      cont    <= wdata[CONT_B];
      ch      <= wdata[CHW-1:0];
      flag    <= wdata[IEN_B] & wdata[FLAG_B];
      first   <= 1'b1;
      irq_q   <= 1'b0;
      start_q <= (wdata[CHW-1:0] != CH_IDLE);
    end else begin
      start_q <= conv_done & cont & (ch != CH_IDLE);
      if (conv_done) first <= 1'b0;
      if (!ien) begin
        if (conv_done && (!cont || first)) flag <= 1'b1;
        else if (data_rd)                  flag <= 1'b0;
      end
      if (ien && !flag && conv_done) irq_q <= 1'b1;
      else if (data_rd)              irq_q <= 1'b0;
    end
  end

  assign start_conv = start_q;
  assign chan       = ch;
  assign cont_mode  = cont;
  assign cpu_irq    = irq_q;
  assign rdata      = ctl_rd ? DW'({flag, ien, cont, ch}) : '0;

  p_chan_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> chan == $past(wdata[CHW-1:0]));
  p_flag_from_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ien && $rose(flag)) |-> $past(conv_done));
  p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_irq && !ctl_wr && !data_rd) |=> cpu_irq);
  p_dma_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ien && flag) |-> !cpu_irq);
  p_idle_no_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_conv |-> chan != CH_IDLE);
  p_write_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !wdata[IEN_B]) |=> (!flag && !cpu_irq));
endmodule

// File: tb/adc_ctl_reg_test.sv
module adc_ctl_reg_test;
  logic clk = 0, rst_n = 0;
  logic reg_sel = 0, wr_en = 0, rd_en = 0, conv_done = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic start_conv, cont_mode, cpu_irq;
  logic [4:0] chan;

  adc_ctl_reg uut (.clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
    .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .conv_done(conv_done),
    .start_conv(start_conv), .chan(chan), .cont_mode(cont_mode), .cpu_irq(cpu_irq));

  always #5 clk = ~clk;

  int compared = 0, mismatched = 0;
  string phase = "R1";
  bit finished = 0;
  int delay = 3, cnt = 0;

  bit m_flag = 0, m_ien = 0, m_cont = 0, m_first = 0, m_irq = 0, m_start = 0;
  int m_ch = 31;

  task automatic check(input string what, input int act, input int exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", phase, what, act, exp);
    end
  endtask

  task automatic model(input bit wr, input bit sel, input bit rd, input int wd, input bit done);
    m_start = 0;
    if (wr && !sel) begin
      m_ien = wd[6]; m_cont = wd[5]; m_ch = wd & 31;
      m_flag = m_ien ? wd[7] : 0;
      m_first = 1; m_irq = 0; m_start = (m_ch != 31);
    end else begin
      if (rd && sel) begin
        if (!m_ien) m_flag = 0;
        m_irq = 0;
      end
      if (done) begin
        if (!m_ien) begin
          if (!m_cont || m_first) m_flag = 1;
        end else if (!m_flag) m_irq = 1;
        m_first = 0;
        if (m_cont && m_ch != 31) m_start = 1;
      end
    end
  endtask

  task automatic compare_all();
    int exp_rd;
    exp_rd = (rd_en && !reg_sel) ? {m_flag, m_ien, m_cont, m_ch[4:0]} : 0;
    check("rdata", rdata, exp_rd);
    check("start_conv", start_conv, m_start);
    check("chan", chan, m_ch);
    check("cont_mode", cont_mode, m_cont);
    check("cpu_irq", cpu_irq, m_irq);
  endtask

  task automatic step(input bit wr, input bit sel, input bit rd, input int wd, input bit fd);
    bit d;
    d = fd || (cnt == 1);
    wr_en = wr; reg_sel = sel; rd_en = rd; wdata = wd[7:0]; conv_done = d;
    @(posedge clk);
    model(wr, sel, rd, wd, d);
    if (cnt > 0) cnt--;
    #2;
    wr_en = 0; conv_done = 0;
    compare_all();
    if (start_conv && cnt == 0) cnt = delay;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0);
  endtask

  task automatic peek();
    rd_en = 1; reg_sel = 0; #1;
    check("status read", rdata, {m_flag, m_ien, m_cont, m_ch[4:0]});
    rd_en = 0;
  endtask

  initial begin
    #200000;
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    #22 rst_n = 1;
    #3;
    phase = "R1"; compare_all(); peek(); check("R1 reset value", rdata, 8'h1F);
    step(0, 0, 1, 0, 0);

    phase = "R2"; step(1, 0, 0, 8'h83, 0); peek();
    phase = "R3"; idle(5); peek();
    phase = "R5"; step(0, 1, 1, 0, 0); peek();
    step(1, 0, 0, 8'h04, 0); idle(5);
    step(1, 0, 0, 8'h04, 0); peek();

    phase = "R4"; step(1, 0, 0, 8'h22, 0); idle(6); peek();
    step(0, 1, 1, 0, 0); idle(9); peek();
    phase = "R10"; step(1, 0, 0, 8'h02, 0); idle(6);
    step(1, 0, 0, 8'h22, 0); idle(4); step(1, 0, 0, 8'h3F, 0); idle(6);

    phase = "R11"; step(1, 0, 0, 8'h1F, 0); idle(2);
    step(1, 0, 0, 8'h9F, 1); peek(); idle(2);

    phase = "R7"; step(1, 0, 0, 8'h45, 0); idle(6); peek();
    step(0, 1, 1, 0, 0); idle(2);
    step(1, 0, 0, 8'h45, 0); idle(5); step(1, 0, 0, 8'h5F, 0);
    phase = "R8"; step(1, 0, 0, 8'hC5, 0); idle(6);
    phase = "R6"; peek(); step(0, 1, 1, 0, 0); peek();
    step(1, 0, 0, 8'h5F, 0); peek();

    phase = "R9"; step(1, 0, 0, 8'h1F, 0); idle(3);
    step(1, 0, 0, 8'h07, 0); idle(5);
    phase = "R12"; step(1, 1, 0, 8'hE3, 0); peek(); step(0, 0, 1, 0, 0); idle(2); peek();

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule